// File: doc/BRIEF.md
# Mode-Selected Serial Measurement Frame Sequencer

This block sends a burst of 32-bit measurement words out of a single data line, one bit per clock, with the most significant bit first. When a start request arrives, it captures a parallel snapshot of sixteen word slots. A two-bit mode field then picks which slots are sent and in what order. The snapshot holds the three phase current and voltage waveform samples, a neutral-current sample, and the apparent, active and reactive power of each phase.

Two variant inputs say whether the neutral-current channel and the reactive-power words exist on the device. A slot that does not exist is sent as an all-zero word, so the burst length depends on the mode alone. A frame strobe with selectable polarity covers the whole burst. A one-cycle done pulse marks the end of the burst.

Snapshot layout on `meas` uses slot i at bits `[32*i +: 32]`:

| Slots | Content |
|-------|---------|
| 0 to 5 | waveform samples: current A, voltage A, current B, voltage B, current C, voltage C |
| 6 | neutral-current sample |
| 7, 8, 9 | apparent power of phases A, B, C |
| 10, 11, 12 | active power of phases A, B, C |
| 13, 14, 15 | reactive power of phases A, B, C |

Top module: `frame_seq`

## Requirements
- R1: After reset, `sdata` is 0, `done` is 0 and `frame` is at its inactive level, which is the inverse of `frame_pol`.
- R2: In mode 2'b00 the burst is sixteen words, sent as slots 0 through 15 in ascending order.
- R3: When `has_neutral` is 0 at start, slot 6 is sent as a zero word in modes 00, 01 and 11.
- R4: When `has_reactive` is 0 at start, slots 13 to 15 are sent as zero words in modes 00, 10 and 11.
- R5: In mode 2'b01 the burst is seven words, slots 0 through 6 in ascending order.
- R6: In mode 2'b10 the burst is nine words, slots 7 through 15 in ascending order.
- R7: Mode 2'b11 produces the same burst as mode 2'b00.
- R8: `frame` is high while a burst runs if `frame_pol` is 1, and low while a burst runs if `frame_pol` is 0.
- R9: The first bit appears in the cycle after the clock edge that accepts `start`. Each word is sent MSB first, one bit per cycle, with no gaps. `frame` stays active for exactly words x 32 cycles.
- R10: Mode, variant flags and snapshot are captured when a burst starts. Later changes to `meas`, `mode`, `has_neutral` or `has_reactive` do not alter the words being sent.
- R11: A `start` request that arrives while a burst is running is ignored.
- R12: `done` is high for exactly one cycle, the cycle right after the final bit. In that cycle `frame` is already inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | serial bit clock |
| rst_n | input | 1 | asynchronous reset, active low |
| start | input | 1 | burst request, accepted when idle |
| mode | input | 2 | word-order select |
| has_neutral | input | 1 | neutral-current slot exists |
| has_reactive | input | 1 | reactive-power slots exist |
| frame_pol | input | 1 | frame strobe active level (1 = high) |
| meas | input | 512 | snapshot of sixteen 32-bit slots |
| sdata | output | 1 | serial data, MSB first |
| frame | output | 1 | frame-active strobe |
| done | output | 1 | one-cycle end-of-burst pulse |

## Verification
The assertions assume that `frame_pol` is held steady for the length of a burst, because the strobe level follows that input directly. The stimulus changes `frame_pol` only between bursts. The assertions take nothing else for granted: `start`, `mode`, the variant flags and `meas` may change at any cycle. To exercise this, the random bursts deliberately toggle `start`, flip `mode` and replace the snapshot partway through a transfer. The expected words are still computed from the values captured when the burst began.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int WORD_W = 32,
  parameter int NSLOT  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              mode,
  input  logic                    has_neutral,
  input  logic                    has_reactive,
  input  logic                    frame_pol,
  input  logic [NSLOT*WORD_W-1:0] meas,
  output logic                    sdata,
  output logic                    frame,
  output logic                    done
);
  localparam int BW = $clog2(WORD_W);
  localparam int SW = $clog2(NSLOT);
  localparam logic [SW-1:0] NEUTRAL_SLOT = SW'(6);
  localparam logic [SW-1:0] VAR_FIRST    = SW'(13);
  localparam logic [SW-1:0] POWER_FIRST  = SW'(7);

  logic [WORD_W-1:0] snap [NSLOT];
  logic              busy, neu_l, var_l;
  logic [1:0]        mode_l;
  logic [SW-1:0]     widx, last_w, src;
  logic [BW-1:0]     bidx;
  logic              zero_slot;
  logic [WORD_W-1:0] word;

  always_comb begin
    case (mode_l)
      2'b01:   last_w = SW'(6);
      2'b10:   last_w = SW'(8);
      default: last_w = SW'(NSLOT-1);
    endcase
  end

  assign src       = (mode_l == 2'b10) ? widx + POWER_FIRST : widx;
  assign zero_slot = (src == NEUTRAL_SLOT && !neu_l) || (src >= VAR_FIRST && !var_l);
  assign word      = zero_slot ? '0 : snap[src];
  assign sdata     = busy & word[BW'(WORD_W-1) - bidx];
  assign frame     = frame_pol ? busy : ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      widx   <= '0;
      bidx   <= '0;
      mode_l <= 2'b00;
      neu_l  <= 1'b0;
      var_l  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          widx   <= '0;
          bidx   <= '0;
          mode_l <= mode;
          neu_l  <= has_neutral;
          var_l  <= has_reactive;
        end
      end else if (bidx == BW'(WORD_W-1)) begin
        bidx <= '0;
        if (widx == last_w) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          widx <= widx + 1'b1;
        end
      end else begin
        bidx <= bidx + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_snap
    always_ff @(posedge clk)
      if (!busy && start) snap[i] <= meas[i*WORD_W +: WORD_W];
  end

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_done_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(mode_l) && $stable(neu_l) && $stable(var_l));
  a_r3_neutral_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busy && src == NEUTRAL_SLOT && !neu_l |-> !sdata);
  a_r4_reactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busy && src >= VAR_FIRST && !var_l |-> !sdata);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdata);
endmodule

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic has_neutral = 1'b0, has_reactive = 1'b0, frame_pol = 1'b0;
  logic [16*32-1:0] meas = '0;
  logic sdata, frame, done;
  int checks = 0, failures = 0, cycles = 0;

  frame_seq u_frame_seq (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .has_neutral(has_neutral), .has_reactive(has_reactive), .frame_pol(frame_pol),
    .meas(meas), .sdata(sdata), .frame(frame), .done(done));

  always #5 clk = ~clk;

  function automatic int n_words(input logic [1:0] m);
    return (m == 2'b01) ? 7 : (m == 2'b10) ? 9 : 16;
  endfunction

  function automatic int slot_of(input logic [1:0] m, input int k);
    return (m == 2'b10) ? k + 7 : k;
  endfunction

  function automatic logic [31:0] exp_word(input logic [16*32-1:0] s, input logic [1:0] m,
                                           input logic n, input logic v, input int k);
    int src = slot_of(m, k);
    if ((src == 6 && !n) || (src >= 13 && !v)) return 32'h0;
    return s[src*32 +: 32];
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic n, input logic v, input int k);
    int src = slot_of(m, k);
    if (src == 6 && !n) return "R3";
    if (src >= 13 && !v) return "R4";
    case (m)
      2'b01: return "R5";
      2'b10: return "R6";
      2'b11: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [16*32-1:0] rnd_meas();
    logic [16*32-1:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic burst(input logic [1:0] m, input logic n, input logic v, input logic p,
                       input logic disturb);
    logic [16*32-1:0] held;
    logic [31:0] got;
    int frame_bad = 0, done_bad = 0;
    held = rnd_meas();
    meas = held; mode = m; has_neutral = n; has_reactive = v; frame_pol = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n_words(m); k++) begin
      for (int b = 31; b >= 0; b--) begin
        got[b] = sdata;
        if (frame !== p) frame_bad++;
        if (done !== 1'b0) done_bad++;
        if (disturb && k == 1 && b == 20) begin
          meas = rnd_meas(); start = 1'b1; mode = ~m;
          has_neutral = ~n; has_reactive = ~v;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
      check(disturb ? {tag_of(m, n, v, k), " R10/R11"} : tag_of(m, n, v, k),
            got, exp_word(held, m, n, v, k));
    end
    check("R8/R9 frame active for whole burst", frame_bad, 0);
    check("R12 no early done", done_bad, 0);
    check("R12 done after last bit", {31'b0, done}, 32'd1);
    check("R12 frame inactive with done", {31'b0, frame}, {31'b0, ~p});
    @(negedge clk);
    check("R12 done single cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 sdata at reset", {31'b0, sdata}, 32'd0);
    check("R1 done at reset", {31'b0, done}, 32'd0);
    check("R1 frame inactive at reset", {31'b0, frame}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      for (int nv = 0; nv < 4; nv++)
        burst(2'(m), nv[0], nv[1], 1'b0, 1'b0);
    burst(2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
    burst(2'b01, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 24; i++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      burst(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule